// File: doc/BRIEF.md
# Identity-Steered Shared-Opcode Decode Unit

This block sits in the decode stage of a core whose extensions overlap in encoding space. It holds a writable vendor/architecture identity pair and uses it to decide which extension decoder owns the two shared opcode slots. The identity can only take values from a small legal table. Each table entry hands the shared slots to exactly one decode engine, so an instruction word never enables two engines at once. Engine 0 is the standard decoder. Engines 1 to 3 are extension decoders that sit side by side. Steering only gates each engine's match with one enable term. It never touches engine state, so software can switch meanings inside a loop with a single write.

A legal identity write moves the control state machine from ST_RUN to ST_SW1, then to ST_SW2, then back to ST_RUN. The transitions are: ST_RUN to ST_SW1 on an accepted write, ST_SW1 to ST_SW2 always, ST_SW2 to ST_RUN always, and ST_RUN stays in ST_RUN otherwise. The block raises `stall` in both switch states and decodes nothing while it is raised. A write of an unknown tuple is resolved by keeping the current entry. When the block is built with a fixed identity, writes have no effect and only the standard decoder can ever be enabled.

Top module: `ext_decode_steer`

## Requirements
- R1: After reset the identity reads vendor 0, arch 0 (table entry 0, the standard-only tuple) and `stall` is low.
- R2: A write made in ST_RUN of a tuple from the table is accepted. The readback shows the new tuple from the cycle after the write. Entry 0 is (0,0). Entry i, for i in 1..3, is (0xA5C, 0x1000+i).
- R3: A write of a tuple not in the table leaves the readback unchanged and does not raise `stall`.
- R4: After an accepted write, `stall` is high for exactly 2 cycles. During those cycles all engine enables and the illegal flag are low, and any identity write is ignored.
- R5: A valid, non-stalled word that is nonzero, has bits[1:0]=11, and whose opcode bits[6:0] are not 0x0B or 0x2B enables engine 0 (bit 0) only.
- R6: Opcode 0x0B is shared slot 0 and opcode 0x2B is shared slot 1. Under entry i (i>0), a shared word enables only bit i, provided engine i supports that slot. Engine 1 supports both slots, engine 2 supports slot 0 only, and engine 3 supports slot 1 only.
- R7: A valid, non-stalled word that no engine claims raises `illegal_instr`. This covers a shared word under entry 0, an unsupported slot, bits[1:0]≠11, and the all-zero word.
- R8: `eng_en` never has more than one bit high. With `instr_valid` low, both `eng_en` and `illegal_instr` are low.
- R9: With ID_WRITABLE=0, writes never change the readback from (0,0), `stall` stays low, and only engine 0 can be enabled.
- R10: A word presented in the same cycle as an accepted write is decoded under the old tuple. The first word after the stall is decoded under the new tuple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Identity write strobe |
| csr_wvendor | input | 32 | Vendor field of the written tuple |
| csr_warch | input | 32 | Architecture field of the written tuple |
| csr_rvendor | output | 32 | Current vendor identity |
| csr_rarch | output | 32 | Current architecture identity |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| eng_en | output | 4 | One-hot decode enable per engine (bit 0 = standard) |
| illegal_instr | output | 1 | Valid word claimed by no engine |
| stall | output | 1 | Identity switch in progress |

## Verification
The hardest case to reach is a write that arrives while a switch is already in progress. The bench issues a second legal write in the first stall cycle. It then checks that the readback still holds the first tuple and that the stall ends after exactly two cycles. Routing under the old and new tuples is tested with a shared word in the same cycle as the write and again right after the stall. Each of the four entries is visited, which brings out the slot each engine leaves unsupported.

// File: rtl/eds_pkg.sv
package eds_pkg;
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_SW1 = 2'd1,
        ST_SW2 = 2'd2
    } sw_state_t;

    localparam int NUM_SLOTS = 2;

    // opcode of shared slot s: 0x0B, 0x2B
    function automatic logic [6:0] slot_opcode(input int s);
        return 7'h0B | 7'(s << 5);
    endfunction

    // slots engine e (e>0) supports: 1 -> both, 2 -> slot 0, 3 -> slot 1
    function automatic logic [NUM_SLOTS-1:0] slot_mask(input int e);
        if (e == 0) return '0;
        case (e % 3)
            1: return 2'b11;
            2: return 2'b01;
            default: return 2'b10;
        endcase
    endfunction
endpackage

// File: rtl/eds_id_table.sv
module eds_id_table #(
    parameter int          NUM_ENTRIES = 4,
    parameter logic [31:0] VENDOR_BASE = 32'h0000_0A5C,
    parameter logic [31:0] ARCH_BASE   = 32'h0000_1000,
    localparam int         IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [31:0]      q_vendor,
    input  logic [31:0]      q_arch,
    input  logic [IDX_W-1:0] cur_idx,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [31:0]      rd_vendor,
    output logic [31:0]      rd_arch
);
    function automatic logic [31:0] ent_vendor(input int i);
        return (i == 0) ? 32'h0 : VENDOR_BASE;
    endfunction

    function automatic logic [31:0] ent_arch(input int i);
        return (i == 0) ? 32'h0 : ARCH_BASE + 32'(i);
    endfunction

    logic [NUM_ENTRIES-1:0] match;
    logic [NUM_ENTRIES-1:0][31:0] vend_tab;
    logic [NUM_ENTRIES-1:0][31:0] arch_tab;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        assign vend_tab[i] = ent_vendor(i);
        assign arch_tab[i] = ent_arch(i);
        assign match[i]    = (q_vendor == vend_tab[i]) && (q_arch == arch_tab[i]);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign rd_vendor = vend_tab[cur_idx];
    assign rd_arch   = arch_tab[cur_idx];
endmodule

// File: rtl/eds_match.sv
module eds_match
    import eds_pkg::*;
#(
    parameter  int NUM_ENG = 4,
    localparam int IDX_W   = $clog2(NUM_ENG)
) (
    input  logic [31:0]      instr,
    input  logic             decode_ok,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [NUM_ENG-1:0] claim
);
    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 base_ok;
    logic [NUM_ENG-1:0]   owner_en;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_hit[s] = (instr[6:0] == slot_opcode(s));
    end

    assign base_ok = decode_ok && (instr[1:0] == 2'b11) && (instr != 32'h0);

    // the one extra enable term per engine
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        assign owner_en[e] = (sel_idx == IDX_W'(e));
        if (e == 0) begin : g_std
            assign claim[e] = base_ok && !(|slot_hit);
        end else begin : g_ext
            assign claim[e] = base_ok && owner_en[e] && |(slot_hit & slot_mask(e));
        end
    end

    logic unused_owner0;
    assign unused_owner0 = owner_en[0];
endmodule

// File: rtl/ext_decode_steer.sv
module ext_decode_steer
    import eds_pkg::*;
#(
    parameter  int          NUM_ENTRIES = 4,
    parameter  bit          ID_WRITABLE = 1'b1,
    parameter  logic [31:0] VENDOR_BASE = 32'h0000_0A5C,
    parameter  logic [31:0] ARCH_BASE   = 32'h0000_1000,
    localparam int          NUM_ENG     = NUM_ENTRIES,
    localparam int          IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_wr,
    input  logic [31:0]        csr_wvendor,
    input  logic [31:0]        csr_warch,
    output logic [31:0]        csr_rvendor,
    output logic [31:0]        csr_rarch,
    input  logic               instr_valid,
    input  logic [31:0]        instr,
    output logic [NUM_ENG-1:0] eng_en,
    output logic               illegal_instr,
    output logic               stall
);
    sw_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             tbl_hit;
    logic [IDX_W-1:0] tbl_idx;
    logic             accept;
    logic             decode_ok;
    logic [NUM_ENG-1:0] claim;

    eds_id_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .VENDOR_BASE (VENDOR_BASE),
        .ARCH_BASE   (ARCH_BASE)
    ) u_table (
        .q_vendor  (csr_wvendor),
        .q_arch    (csr_warch),
        .cur_idx   (idx_q),
        .hit       (tbl_hit),
        .hit_idx   (tbl_idx),
        .rd_vendor (csr_rvendor),
        .rd_arch   (csr_rarch)
    );

    eds_match #(.NUM_ENG(NUM_ENG)) u_match (
        .instr     (instr),
        .decode_ok (decode_ok),
        .sel_idx   (idx_q),
        .claim     (claim)
    );

    assign accept = ID_WRITABLE && csr_wr && (state_q == ST_RUN) && tbl_hit;

    always_comb begin
        unique case (state_q)
            ST_RUN:  state_d = accept ? ST_SW1 : ST_RUN;
            ST_SW1:  state_d = ST_SW2;
            ST_SW2:  state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) idx_q <= tbl_idx;
        end
    end

    always_comb begin
        stall         = 1'b0;
        decode_ok     = 1'b0;
        eng_en        = '0;
        illegal_instr = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                decode_ok     = instr_valid;
                eng_en        = claim;
                illegal_instr = instr_valid && !(|claim);
            end
            ST_SW1, ST_SW2: stall = 1'b1;
            default: stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/eds_checker.sv
module eds_checker #(
    parameter int NUM_ENG     = 4,
    parameter bit ID_WRITABLE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               csr_wr,
    input logic [31:0]        csr_rvendor,
    input logic [31:0]        csr_rarch,
    input logic               instr_valid,
    input logic [NUM_ENG-1:0] eng_en,
    input logic               illegal_instr,
    input logic               stall,
    input logic               tbl_hit
);
    // R8
    onehot_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_en));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (eng_en == '0) && !illegal_instr);

    // R7
    illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_instr |-> (eng_en == '0));

    // R4
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (eng_en == '0) && !illegal_instr);

    // R4
    stall_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |=> stall);

    // R4
    stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall && $past(stall) |=> !stall);

    // R3
    unknown_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr && !stall && !tbl_hit |=> $stable(csr_rvendor) && $stable(csr_rarch) && !stall);

    // R2
    legal_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ID_WRITABLE && csr_wr && !stall && tbl_hit |=> stall);

    // R9
    fixed_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ID_WRITABLE |-> !stall && (eng_en[NUM_ENG-1:1] == '0));
endmodule

bind ext_decode_steer eds_checker #(
    .NUM_ENG     (NUM_ENG),
    .ID_WRITABLE (ID_WRITABLE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_wr        (csr_wr),
    .csr_rvendor   (csr_rvendor),
    .csr_rarch     (csr_rarch),
    .instr_valid   (instr_valid),
    .eng_en        (eng_en),
    .illegal_instr (illegal_instr),
    .stall         (stall),
    .tbl_hit       (tbl_hit)
);

// File: tb/ext_decode_steer_bench.sv
module ext_decode_steer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wvendor = '0;
    logic [31:0] csr_warch = '0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;

    logic [31:0] rv, ra, ro_rv, ro_ra;
    logic [3:0]  en, ro_en;
    logic        ill, stl, ro_ill, ro_stl;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ext_decode_steer u_ext_decode_steer (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wvendor(csr_wvendor),
        .csr_warch(csr_warch), .csr_rvendor(rv), .csr_rarch(ra),
        .instr_valid(instr_valid), .instr(instr), .eng_en(en),
        .illegal_instr(ill), .stall(stl)
    );

    ext_decode_steer #(.ID_WRITABLE(1'b0)) u_ext_decode_steer_ro (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wvendor(csr_wvendor),
        .csr_warch(csr_warch), .csr_rvendor(ro_rv), .csr_rarch(ro_ra),
        .instr_valid(instr_valid), .instr(instr), .eng_en(ro_en),
        .illegal_instr(ro_ill), .stall(ro_stl)
    );

    typedef struct {
        string       tag;
        logic [3:0]  en;
        logic        ill;
        logic        stl;
        logic [31:0] rv;
        logic [31:0] ra;
        logic [3:0]  ro_en;
        logic        ro_ill;
    } exp_t;

    exp_t q[$];

    // bench-side model state
    int m_idx = 0;
    int m_scnt = 0;

    function automatic logic [31:0] tv(input int i);
        return (i == 0) ? 32'h0 : 32'h0000_0A5C;
    endfunction
    function automatic logic [31:0] ta(input int i);
        return (i == 0) ? 32'h0 : 32'h0000_1000 + 32'(i);
    endfunction
    function automatic int lookup(input logic [31:0] v, input logic [31:0] a);
        for (int i = 0; i < 4; i++) if (v == tv(i) && a == ta(i)) return i;
        return -1;
    endfunction

    function automatic void decode(input int idx, input logic v, input logic [31:0] w,
                                   input logic stalled, output logic [3:0] e, output logic il);
        logic [1:0] mask;
        int slot;
        e = 4'b0; il = 1'b0;
        if (!v || stalled) return;
        if (w == 32'h0 || w[1:0] != 2'b11) begin il = 1'b1; return; end
        slot = (w[6:0] == 7'h0B) ? 0 : (w[6:0] == 7'h2B) ? 1 : -1;
        if (slot < 0) begin e = 4'b0001; return; end
        mask = (idx == 1) ? 2'b11 : (idx == 2) ? 2'b01 : (idx == 3) ? 2'b10 : 2'b00;
        if (mask[slot]) e = 4'(1 << idx);
        else il = 1'b1;
    endfunction

    task automatic step(input string tag, input logic wr, input logic [31:0] wv,
                        input logic [31:0] wa, input logic v, input logic [31:0] w);
        exp_t x;
        int hit;
        @(posedge clk); #1;
        csr_wr = wr; csr_wvendor = wv; csr_warch = wa; instr_valid = v; instr = w;
        x.tag = tag;
        decode(m_idx, v, w, m_scnt > 0, x.en, x.ill);
        x.stl = (m_scnt > 0);
        x.rv = tv(m_idx); x.ra = ta(m_idx);
        decode(0, v, w, 1'b0, x.ro_en, x.ro_ill);
        q.push_back(x);
        if (m_scnt > 0) m_scnt--;
        else if (wr) begin
            hit = lookup(wv, wa);
            if (hit >= 0) begin m_idx = hit; m_scnt = 2; end
        end
    endtask

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            cmp(x.tag, "eng_en", 32'(en), 32'(x.en));
            cmp(x.tag, "illegal", 32'(ill), 32'(x.ill));
            cmp(x.tag, "stall", 32'(stl), 32'(x.stl));
            cmp(x.tag, "rvendor", rv, x.rv);
            cmp(x.tag, "rarch", ra, x.ra);
            cmp({x.tag, "/R9"}, "ro_eng_en", 32'(ro_en), 32'(x.ro_en));
            cmp({x.tag, "/R9"}, "ro_illegal", 32'(ro_ill), 32'(x.ro_ill));
            cmp({x.tag, "/R9"}, "ro_stall", 32'(ro_stl), 32'h0);
            cmp({x.tag, "/R9"}, "ro_id", {ro_rv[15:0], ro_ra[15:0]}, 32'h0);
        end
    end

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    localparam logic [31:0] STD = 32'h0000_0013;
    localparam logic [31:0] SH0 = 32'h0000_100B;
    localparam logic [31:0] SH1 = 32'h0000_202B;
    localparam logic [31:0] VN  = 32'h0000_0A5C;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step("R1 reset", 0, 0, 0, 0, 0);
        step("R5 std", 0, 0, 0, 1, STD);
        step("R7 shared under entry0", 0, 0, 0, 1, SH0);
        step("R7 compressed", 0, 0, 0, 1, 32'h0000_0001);
        step("R7 zero word", 0, 0, 0, 1, 32'h0);
        step("R8 idle", 0, 0, 0, 0, SH0);
        step("R3 unknown tuple", 1, VN, 32'h0000_1009, 1, STD);
        step("R3 after unknown", 0, 0, 0, 1, SH1);
        step("R10 write entry1 old meaning", 1, VN, 32'h0000_1001, 1, SH0);
        step("R4 stall1 write ignored", 1, VN, 32'h0000_1002, 1, SH0);
        step("R4 stall2", 0, 0, 0, 1, STD);
        step("R10 R6 entry1 slot0", 0, 0, 0, 1, SH0);
        step("R6 entry1 slot1", 0, 0, 0, 1, SH1);
        step("R5 std under entry1", 0, 0, 0, 1, STD);
        step("R2 write entry2", 1, VN, 32'h0000_1002, 0, 0);
        step("R4 s1", 0, 0, 0, 1, SH0);
        step("R4 s2", 0, 0, 0, 1, SH0);
        step("R6 entry2 slot0", 0, 0, 0, 1, SH0);
        step("R7 entry2 slot1 unsupported", 0, 0, 0, 1, SH1);
        step("R2 write entry3", 1, VN, 32'h0000_1003, 1, SH1);
        step("R4 s1", 0, 0, 0, 1, SH1);
        step("R4 s2", 0, 0, 0, 1, SH1);
        step("R6 entry3 slot1", 0, 0, 0, 1, SH1);
        step("R7 entry3 slot0 unsupported", 0, 0, 0, 1, SH0);
        step("R3 vendor match arch miss", 1, VN, 32'h0000_1000, 1, SH1);
        step("R2 back to entry0", 1, 0, 0, 1, STD);
        step("R4 s1", 0, 0, 0, 0, 0);
        step("R4 s2", 0, 0, 0, 0, 0);
        step("R7 shared after return", 0, 0, 0, 1, SH1);
        step("R5 std after return", 0, 0, 0, 1, STD);
        step("R8 final idle", 0, 0, 0, 0, 0);
        @(posedge clk);
        @(negedge clk); #1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule